// File: doc/BRIEF.md
# Floating-Point Block Load Sequencer

This block carries out one block-load command into a 32-entry floating-point register file. A decoded command arrives as a single-cycle strobe carrying the three addressing-mode bits, an 8-bit count immediate, a four-bit register field with one extra index bit, a precision select, the number of the base register and the base value. The block checks the command, then fetches 32-bit words from memory one at a time and writes them to the register file, either as single 32-bit registers or as 64-bit doubles built from two consecutive words.

Addresses always climb from the starting point. An ascending command starts at the base and a descending one starts at the base minus the byte span, where the byte span is the immediate times four. When the command asks for writeback, the updated base is presented together with the completion pulse. Commands that belong to a different operation, that are undefined, or whose register range is unpredictable are refused with an error pulse and a code, and they touch neither memory nor the register file.

Top module: `fbl_block_load`

## Requirements
- R1: The mode bits are cmd_mode = {P,U,W}, where bit 2 is P, bit 1 is U and bit 0 is W. Only 010 (ascending), 011 (ascending with writeback) and 101 (descending with writeback) are executed. 000, 100 and 110 are refused with err_code 1. 001 and 111 are refused with err_code 2.
- R2: In single mode (cmd_dbl=0) the register count equals cmd_imm and the first index is {cmd_vd,cmd_dbit}. In double mode the count is cmd_imm>>1 and the first index is {cmd_dbit,cmd_vd}. Registers are written at consecutive rising indices starting at the first index.
- R3: An accepted mode is refused with err_code 3 when any of these holds: the count is zero, the first index plus the count exceeds 32, the mode is double and the count exceeds 16, or cmd_base_idx is 15 while W=1. Code 1 takes precedence over code 2, and code 2 over code 3.
- R4: The first read address is cmd_base when U=1, or cmd_base minus 4*cmd_imm when U=0. Each further read is 4 bytes above the one before it.
- R5: Each read request is a one-cycle rd_req pulse. No new request is issued until rd_valid has returned the previous word.
- R6: In single mode each word is written to its own register with rf_dbl=0, in rf_data[31:0], with rf_data[63:32] set to zero.
- R7: In double mode each register takes the words from addr and addr+4. rf_data is {first,second} when big_endian=1 and {second,first} when big_endian=0. The value of big_endian is taken when the command is accepted.
- R8: At completion wb_en equals W. wb_value is cmd_base+4*cmd_imm when U=1 and cmd_base-4*cmd_imm when U=0.
- R9: A refused command issues no read and no register write. It raises err_pulse for one cycle, the cycle after acceptance, and the block is idle on the next cycle.
- R10: After the last register write the done pulse lasts one cycle, and the block is idle on the next cycle. After reset, rd_req, rf_we, done, err_pulse and busy are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, sampled only while idle |
| cmd_mode | input | 3 | Addressing bits {P,U,W} |
| cmd_imm | input | 8 | Count immediate |
| cmd_vd | input | 4 | Register field of the first index |
| cmd_dbit | input | 1 | Extra index bit |
| cmd_dbl | input | 1 | 1 selects double precision |
| cmd_base_idx | input | 4 | Number of the base register |
| cmd_base | input | 32 | Base address value |
| big_endian | input | 1 | Word order used to pair doubles |
| busy | output | 1 | A command is in progress |
| rd_req | output | 1 | One-cycle memory read request |
| rd_addr | output | 32 | Read address |
| rd_valid | input | 1 | Read data return |
| rd_data | input | 32 | Returned word |
| rf_we | output | 1 | Register file write strobe |
| rf_idx | output | 5 | Register index |
| rf_dbl | output | 1 | The write is a 64-bit register |
| rf_data | output | 64 | Write data |
| done | output | 1 | Completion pulse |
| wb_en | output | 1 | Base writeback requested, valid with done |
| wb_value | output | 32 | New base value, valid with done |
| err_pulse | output | 1 | Refusal pulse |
| err_code | output | 2 | Refusal reason, valid with err_pulse |

## Verification
The assertions check four properties on every cycle. Requests are single-cycle and never overlap an outstanding read. Consecutive requests within one command are exactly four bytes apart. Error pulses are quiet and carry a nonzero code, and register writes and done pulses never last two cycles. The bench's sweep covers the rest. It runs every mode combination in both precisions, with counts and first indices placed on either side of the 32-register and 16-double limits, the base register number 15, and both word orders. Only these scenarios can show that the decode gives the right code, that the start address and writeback value are right, and that each register gets the right index and word pairing.

// File: rtl/fbl_pkg.sv
package fbl_pkg;
  typedef enum logic [1:0] {
    FBL_OK       = 2'd0,
    FBL_OTHER_OP = 2'd1,
    FBL_UNDEF    = 2'd2,
    FBL_UNPRED   = 2'd3
  } fbl_err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ERR,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } fbl_state_e;
endpackage

// File: rtl/fbl_decode.sv
module fbl_decode
  import fbl_pkg::*;
#(
  parameter int unsigned IMM_W      = 8,
  parameter int unsigned REG_CNT    = 32,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned BASE_IDX_W = 4,
  parameter int unsigned PC_IDX     = 15
) (
  input  logic [2:0]                   mode,
  input  logic [IMM_W-1:0]             imm,
  input  logic [$clog2(REG_CNT)-2:0]   vd,
  input  logic                         dbit,
  input  logic                         dbl,
  input  logic [BASE_IDX_W-1:0]        base_idx,
  input  logic [ADDR_W-1:0]            base,
  output fbl_err_e                     code,
  output logic [IMM_W-1:0]             count,
  output logic [$clog2(REG_CNT)-1:0]   first,
  output logic [ADDR_W-1:0]            start_addr,
  output logic [ADDR_W-1:0]            new_base
);
  localparam int unsigned IDX_W = $clog2(REG_CNT);
  localparam int unsigned SUM_W = IMM_W + 1;
  localparam int unsigned DBL_MAX = REG_CNT / 2;

  function automatic logic [ADDR_W-1:0] byte_span(input logic [IMM_W-1:0] n);
    return {{(ADDR_W-IMM_W-2){1'b0}}, n, 2'b00};
  endfunction

  function automatic logic [IMM_W-1:0] reg_count(input logic [IMM_W-1:0] n, input logic d);
    return d ? (n >> 1) : n;
  endfunction

  function automatic logic [IDX_W-1:0] first_index(input logic [IDX_W-2:0] v, input logic b,
                                                   input logic d);
    return d ? {b, v} : {v, b};
  endfunction

  function automatic fbl_err_e classify(input logic [2:0] m, input logic [IMM_W-1:0] cnt,
                                        input logic [IDX_W-1:0] f, input logic d,
                                        input logic [BASE_IDX_W-1:0] bidx);
    logic [SUM_W-1:0] reach;
    reach = SUM_W'(f) + SUM_W'(cnt);
    if (m == 3'b000 || (m[2] && !m[0])) return FBL_OTHER_OP;
    if (m[0] && (m[2] == m[1]))         return FBL_UNDEF;
    if (cnt == '0)                      return FBL_UNPRED;
    if (reach > SUM_W'(REG_CNT))        return FBL_UNPRED;
    if (d && (cnt > IMM_W'(DBL_MAX)))   return FBL_UNPRED;
    if (m[0] && (bidx == BASE_IDX_W'(PC_IDX))) return FBL_UNPRED;
    return FBL_OK;
  endfunction

  logic [ADDR_W-1:0] span;

  always_comb begin
    span       = byte_span(imm);
    count      = reg_count(imm, dbl);
    first      = first_index(vd, dbit, dbl);
    code       = classify(mode, count, first, dbl, base_idx);
    start_addr = mode[1] ? base : (base - span);
    new_base   = mode[1] ? (base + span) : (base - span);
  end
endmodule

// File: rtl/fbl_addr_walk.sv
module fbl_addr_walk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (load)    addr <= start;
    else if (advance) addr <= addr + ADDR_W'(STEP);
  end
endmodule

// File: rtl/fbl_pair.sv
module fbl_pair #(
  parameter int unsigned WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold_en,
  input  logic [WORD_W-1:0]   word_in,
  input  logic                dbl,
  input  logic                big_endian,
  output logic [2*WORD_W-1:0] packed_out
);
  logic [WORD_W-1:0] held_q;

  function automatic logic [2*WORD_W-1:0] pack(input logic [WORD_W-1:0] lo_addr_word,
                                               input logic [WORD_W-1:0] hi_addr_word,
                                               input logic d, input logic be);
    if (!d)  return {{WORD_W{1'b0}}, hi_addr_word};
    if (be)  return {lo_addr_word, hi_addr_word};
    return {hi_addr_word, lo_addr_word};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (hold_en) held_q <= word_in;
  end

  assign packed_out = pack(held_q, word_in, dbl, big_endian);
endmodule

// File: rtl/fbl_block_load.sv
module fbl_block_load
  import fbl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned IMM_W      = 8,
  parameter int unsigned REG_CNT    = 32,
  parameter int unsigned BASE_IDX_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [2:0]                   cmd_mode,
  input  logic [IMM_W-1:0]             cmd_imm,
  input  logic [$clog2(REG_CNT)-2:0]   cmd_vd,
  input  logic                         cmd_dbit,
  input  logic                         cmd_dbl,
  input  logic [BASE_IDX_W-1:0]        cmd_base_idx,
  input  logic [ADDR_W-1:0]            cmd_base,
  input  logic                         big_endian,
  output logic                         busy,
  output logic                         rd_req,
  output logic [ADDR_W-1:0]            rd_addr,
  input  logic                         rd_valid,
  input  logic [WORD_W-1:0]            rd_data,
  output logic                         rf_we,
  output logic [$clog2(REG_CNT)-1:0]   rf_idx,
  output logic                         rf_dbl,
  output logic [2*WORD_W-1:0]          rf_data,
  output logic                         done,
  output logic                         wb_en,
  output logic [ADDR_W-1:0]            wb_value,
  output logic                         err_pulse,
  output logic [1:0]                   err_code
);
  localparam int unsigned IDX_W = $clog2(REG_CNT);
  localparam int unsigned STEP  = WORD_W / 8;

  fbl_err_e          dec_code;
  logic [IMM_W-1:0]  dec_count;
  logic [IDX_W-1:0]  dec_first;
  logic [ADDR_W-1:0] dec_start;
  logic [ADDR_W-1:0] dec_new_base;

  fbl_decode #(
    .IMM_W(IMM_W), .REG_CNT(REG_CNT), .ADDR_W(ADDR_W), .BASE_IDX_W(BASE_IDX_W), .PC_IDX(15)
  ) u_decode (
    .mode(cmd_mode), .imm(cmd_imm), .vd(cmd_vd), .dbit(cmd_dbit), .dbl(cmd_dbl),
    .base_idx(cmd_base_idx), .base(cmd_base), .code(dec_code), .count(dec_count),
    .first(dec_first), .start_addr(dec_start), .new_base(dec_new_base)
  );

  fbl_state_e        state_q;
  logic [IMM_W-1:0]  left_q;
  logic [IDX_W-1:0]  idx_q;
  logic              dbl_q;
  logic              be_q;
  logic              half_q;
  logic              wb_en_q;
  logic [ADDR_W-1:0] wb_val_q;
  logic [1:0]        err_q;

  // Named internal events
  logic accept_cmd;
  logic accept_bad;
  logic word_ret;
  logic reg_complete;
  logic last_reg;
  logic [2*WORD_W-1:0] packed_word;

  assign accept_cmd   = (state_q == ST_IDLE) && cmd_valid;
  assign accept_bad   = accept_cmd && (dec_code != FBL_OK);
  assign word_ret     = (state_q == ST_WAIT) && rd_valid;
  assign reg_complete = word_ret && (!dbl_q || half_q);
  assign last_reg     = reg_complete && (left_q == IMM_W'(1));

  fbl_addr_walk #(.ADDR_W(ADDR_W), .STEP(STEP)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(accept_cmd), .start(dec_start),
    .advance(word_ret), .addr(rd_addr)
  );

  fbl_pair #(.WORD_W(WORD_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .hold_en(word_ret && dbl_q && !half_q), .word_in(rd_data),
    .dbl(dbl_q), .big_endian(be_q), .packed_out(packed_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      left_q   <= '0;
      idx_q    <= '0;
      dbl_q    <= 1'b0;
      be_q     <= 1'b0;
      half_q   <= 1'b0;
      wb_en_q  <= 1'b0;
      wb_val_q <= '0;
      err_q    <= 2'd0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept_bad) begin
            err_q   <= dec_code;
            state_q <= ST_ERR;
          end else if (accept_cmd) begin
            err_q    <= 2'd0;
            left_q   <= dec_count;
            idx_q    <= dec_first;
            dbl_q    <= cmd_dbl;
            be_q     <= big_endian;
            half_q   <= 1'b0;
            wb_en_q  <= cmd_mode[0];
            wb_val_q <= dec_new_base;
            state_q  <= ST_ISSUE;
          end
        end
        ST_ERR:   state_q <= ST_IDLE;
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (word_ret) begin
            if (reg_complete) begin
              half_q <= 1'b0;
              idx_q  <= idx_q + IDX_W'(1);
              left_q <= left_q - IMM_W'(1);
              state_q <= last_reg ? ST_DONE : ST_ISSUE;
            end else begin
              half_q  <= 1'b1;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_we   <= 1'b0;
      rf_idx  <= '0;
      rf_dbl  <= 1'b0;
      rf_data <= '0;
    end else begin
      rf_we <= reg_complete;
      if (reg_complete) begin
        rf_idx  <= idx_q;
        rf_dbl  <= dbl_q;
        rf_data <= packed_word;
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign rd_req    = (state_q == ST_ISSUE);
  assign done      = (state_q == ST_DONE);
  assign wb_en     = done && wb_en_q;
  assign wb_value  = wb_val_q;
  assign err_pulse = (state_q == ST_ERR);
  assign err_code  = err_q;

  // Checker state for the assertions
  logic              chk_pending_q;
  logic              chk_seen_q;
  logic [ADDR_W-1:0] chk_prev_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_pending_q   <= 1'b0;
      chk_seen_q      <= 1'b0;
      chk_prev_addr_q <= '0;
    end else begin
      if (rd_req)        chk_pending_q <= 1'b1;
      else if (rd_valid) chk_pending_q <= 1'b0;
      if (!busy)         chk_seen_q <= 1'b0;
      else if (rd_req)   chk_seen_q <= 1'b1;
      if (rd_req)        chk_prev_addr_q <= rd_addr;
    end
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> !rd_req); // R5
  AST_NO_OVERLAP_REQ: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> !chk_pending_q); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && chk_seen_q) |-> (rd_addr == chk_prev_addr_q + ADDR_W'(STEP))); // R4
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (!rd_req && !rf_we && err_code != 2'd0)); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> (!done && !busy)); // R10
  AST_RF_SPACED: assert property (@(posedge clk) disable iff (!rst_n) rf_we |=> !rf_we); // R6
endmodule

// File: tb/tb_fbl_block_load.sv
module tb_fbl_block_load;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_mode = '0;
  logic [7:0]  cmd_imm = '0;
  logic [3:0]  cmd_vd = '0;
  logic        cmd_dbit = 1'b0;
  logic        cmd_dbl = 1'b0;
  logic [3:0]  cmd_base_idx = '0;
  logic [31:0] cmd_base = '0;
  logic        big_endian = 1'b0;
  logic        busy, rd_req, rd_valid, rf_we, rf_dbl, done, wb_en, err_pulse;
  logic [31:0] rd_addr, rd_data, wb_value;
  logic [4:0]  rf_idx;
  logic [63:0] rf_data;
  logic [1:0]  err_code;

  int checks = 0;
  int fails = 0;
  int overlap_cnt = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  fbl_block_load dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode), .cmd_imm(cmd_imm),
    .cmd_vd(cmd_vd), .cmd_dbit(cmd_dbit), .cmd_dbl(cmd_dbl), .cmd_base_idx(cmd_base_idx),
    .cmd_base(cmd_base), .big_endian(big_endian), .busy(busy), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data), .rf_we(rf_we),
    .rf_idx(rf_idx), .rf_dbl(rf_dbl), .rf_data(rf_data), .done(done), .wb_en(wb_en),
    .wb_value(wb_value), .err_pulse(err_pulse), .err_code(err_code)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'hC3A5_0F1E;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Memory model: one response per request, latency from the address
  initial begin
    bit pend = 0;
    int wait_n = 0;
    logic [31:0] paddr = '0;
    rd_valid = 1'b0;
    rd_data = '0;
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      if (pend) begin
        if (wait_n == 0) begin
          rd_valid = 1'b1;
          rd_data = mem_word(paddr);
          pend = 0;
        end else wait_n--;
      end
      if (rd_req) begin
        if (pend) overlap_cnt++;
        pend = 1;
        paddr = rd_addr;
        wait_n = int'(rd_addr[3:2]) % 3;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  task automatic run_cmd(input logic [2:0] mode, input logic [7:0] imm, input logic [3:0] vd,
                         input logic dbit, input logic dbl, input logic [3:0] bidx,
                         input logic [31:0] base, input logic be);
    int exp_code, cnt, first, nreads, nwr, ov0;
    logic [31:0] span, start, nb;
    logic [31:0] seen_addr [64];
    logic [4:0]  wr_idx [32];
    logic [63:0] wr_dat [32];
    logic        wr_dbl [32];
    bit got_done, got_err, addr_ok, wr_ok;
    logic [1:0] got_code;
    logic got_wb_en;
    logic [31:0] got_wb;
    nreads = 0; nwr = 0; got_done = 0; got_err = 0; got_code = 0; got_wb_en = 0; got_wb = 0;
    cnt = dbl ? int'(imm) / 2 : int'(imm);
    first = dbl ? int'({dbit, vd}) : int'({vd, dbit});
    span = {22'd0, imm, 2'b00};
    if (mode == 3'b000 || mode == 3'b100 || mode == 3'b110) exp_code = 1;
    else if (mode == 3'b001 || mode == 3'b111) exp_code = 2;
    else if (cnt == 0 || first + cnt > 32 || (dbl && cnt > 16) || (bidx == 4'd15 && mode[0]))
      exp_code = 3;
    else exp_code = 0;
    start = mode[1] ? base : base - span;
    nb    = mode[1] ? base + span : base - span;
    ov0 = overlap_cnt;

    @(negedge clk);
    cmd_mode = mode; cmd_imm = imm; cmd_vd = vd; cmd_dbit = dbit; cmd_dbl = dbl;
    cmd_base_idx = bidx; cmd_base = base; big_endian = be; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    big_endian = ~be;  // later changes must not affect pairing (R7)
    for (int t = 0; t < 3000; t++) begin
      if (rd_req) begin
        if (nreads < 64) seen_addr[nreads] = rd_addr;
        nreads++;
      end
      if (rf_we) begin
        if (nwr < 32) begin
          wr_idx[nwr] = rf_idx; wr_dat[nwr] = rf_data; wr_dbl[nwr] = rf_dbl;
        end
        nwr++;
      end
      if (done) begin got_done = 1; got_wb_en = wb_en; got_wb = wb_value; break; end
      if (err_pulse) begin got_err = 1; got_code = err_code; break; end
      @(negedge clk);
    end
    @(negedge clk);

    if (exp_code != 0) begin
      check(got_err && !got_done, "R1/R3", "error pulse seen", {62'd0, got_err, got_done}, 64'd2);
      check(got_code == 2'(exp_code), (exp_code == 3) ? "R3" : "R1", "err_code",
            64'(got_code), 64'(exp_code));
      check(nreads == 0 && nwr == 0, "R9", "reads/writes on refused command",
            64'(nreads * 256 + nwr), 64'd0);
      check(!busy && !err_pulse, "R9", "idle after error", {62'd0, busy, err_pulse}, 64'd0);
    end else begin
      check(got_done && !got_err, "R10", "done pulse seen", {62'd0, got_done, got_err}, 64'd2);
      check(nreads == cnt * (dbl ? 2 : 1), "R5", "read count", 64'(nreads),
            64'(cnt * (dbl ? 2 : 1)));
      addr_ok = (nreads == cnt * (dbl ? 2 : 1));
      for (int k = 0; k < nreads && k < 64; k++)
        if (seen_addr[k] != start + 32'(4 * k)) addr_ok = 0;
      check(addr_ok, "R4", "read address walk",
            64'((nreads > 0) ? seen_addr[0] : 32'd0), 64'(start));
      check(nwr == cnt && overlap_cnt == ov0, "R5", "writes and no overlapping request",
            64'(nwr), 64'(cnt));
      wr_ok = (nwr == cnt);
      for (int k = 0; k < nwr && k < 32; k++) begin
        logic [31:0] a0, w0, w1;
        logic [63:0] ev;
        a0 = dbl ? start + 32'(8 * k) : start + 32'(4 * k);
        w0 = mem_word(a0);
        w1 = mem_word(a0 + 32'd4);
        ev = !dbl ? {32'd0, w0} : (be ? {w0, w1} : {w1, w0});
        if (wr_idx[k] != 5'(first + k)) wr_ok = 0;
        if (wr_dat[k] != ev || wr_dbl[k] != dbl) wr_ok = 0;
      end
      check(wr_ok, dbl ? "R7" : "R6", "register writes (R2 index)",
            (nwr > 0) ? wr_dat[0] : 64'd0, 64'(first));
      check(got_wb_en == mode[0] && got_wb == nb, "R8", "writeback",
            {31'd0, got_wb_en, got_wb}, {31'd0, mode[0], nb});
      check(!busy && !done, "R10", "idle after done", {62'd0, busy, done}, 64'd0);
    end
  endtask

  initial begin
    logic [7:0] imms [8];
    logic [3:0] vds [3];
    logic       dbs [3];
    int iter = 0;
    imms = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd7, 8'd32, 8'd33, 8'd34};
    vds  = '{4'd0, 4'd15, 4'd7};
    dbs  = '{1'b0, 1'b1, 1'b0};
    repeat (3) @(negedge clk);
    check(!rd_req && !rf_we && !done && !err_pulse && !busy, "R10", "reset state",
          {59'd0, rd_req, rf_we, done, err_pulse, busy}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 8; m++)
      for (int d = 0; d < 2; d++)
        for (int i = 0; i < 8; i++)
          for (int v = 0; v < 3; v++)
            for (int b = 0; b < 2; b++) begin
              iter++;
              run_cmd(3'(m), imms[i], vds[v], dbs[v], d[0], b[0] ? 4'd15 : 4'd3,
                      32'h2000_0000 + 32'(iter * 32'h0000_0134) - 32'h2000_0000 * b,
                      iter[0]);
            end
    // Descending wrap below zero and ascending wrap past the top
    run_cmd(3'b101, 8'd4, 4'd1, 1'b0, 1'b0, 4'd2, 32'h0000_0008, 1'b0);
    run_cmd(3'b011, 8'd4, 4'd2, 1'b1, 1'b1, 4'd2, 32'hFFFF_FFF8, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule